// File: doc/BRIEF.md
# Tagged Eight-Entry Numeric Register Stack

This block stores eight extended-precision values (1 sign bit, 15-bit exponent, 64-bit significand with an explicit integer bit) as a circular register stack. A 3-bit TOP pointer selects the current top entry. Every operand index is counted from TOP, so stack slot ST(i) lives in physical register (TOP + i) mod 8. The stack grows towards lower physical numbers.

Next to the data, the block keeps a 2-bit content tag for each physical register. The tag is worked out from the bits of every value written, so later operations can tell empty, zero, ordinary and special contents apart without decoding the data again. The block reports the current TOP and the packed tag word. It also raises two separate one-cycle flags, one for stack overflow (a push onto an occupied slot) and one for stack underflow (a pop or read of an empty slot).

One operation is accepted per clock: push, pop, read ST(i), write ST(i) or free ST(i). All results are registered and appear on the outputs in the cycle after the operation is presented.

Top module: `numreg_stack`

## Requirements
- R1: After reset, `top_o` is 0, `tagword_o` is all ones (every register empty), and `ovf_o`, `unf_o` are 0.
- R2: A push (op 1) whose target physical register (TOP-1) mod 8 has tag 11 sets TOP to that register and stores `wdata_i` there. Its tag is set from the value. The new TOP and tag are visible in the next cycle.
- R3: A push whose target register has a tag other than 11 raises `ovf_o` for the next cycle only. TOP, all tags and all register contents stay unchanged.
- R4: A pop (op 2) of a non-empty ST(0) presents that register's value on `rdata_o` in the next cycle, sets that physical register's tag to 11 and increments TOP modulo 8.
- R5: A pop of an empty ST(0), or a read of an empty ST(i), raises `unf_o` for the next cycle with `ovf_o` low. TOP and the tags stay unchanged.
- R6: A read (op 3) presents the value of physical register (TOP + `idx_i`) mod 8 on `rdata_o` in the next cycle. TOP and the tags stay unchanged.
- R7: A write (op 4) stores `wdata_i` in physical register (TOP + `idx_i`) mod 8 whatever that register's tag is. It sets the register's tag from the value and leaves TOP unchanged.
- R8: A free (op 5) sets the tag of physical register (TOP + `idx_i`) mod 8 to 11. It leaves TOP and the data unchanged.
- R9: Bits [2k+1:2k] of `tagword_o` hold the tag of physical register k, independent of TOP. The codes are 00 valid, 01 zero, 10 special, 11 empty.
- R10: The tag from a written value follows these rules, applied in order. Exponent 0 with significand 0 gives 01. Exponent 7FFFh gives 10. Exponent 0 with a nonzero significand gives 10. A nonzero exponent with integer bit (bit 63) clear gives 10. Any other value gives 00.
- R11: Op 0 and the unused codes 6 and 7 change nothing. `ovf_o` and `unf_o` are never high together and are low in the cycle after any such op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code (0 none, 1 push, 2 pop, 3 read, 4 write, 5 free) |
| idx_i | input | 3 | Stack index i for read, write and free |
| wdata_i | input | 80 | Value for push and write |
| rdata_o | output | 80 | Value returned by the last pop or read |
| top_o | output | 3 | Current TOP pointer |
| tagword_o | output | 16 | Packed tags, two bits per physical register |
| ovf_o | output | 1 | Stack overflow pulse |
| unf_o | output | 1 | Stack underflow pulse |

## Verification
The hardest states to reach are those where TOP has wrapped past 0 while the stack is partly full and has gaps: freed slots sit between occupied ones, so a push or pop meets a tag that differs from what the stack depth alone would suggest. The stimulus fills all eight slots to force an overflow. It then frees a slot in the middle and pops down onto it to force an underflow. Next it walks TOP through every position while reading each ST(i). It ends with a long weighted random mix of all six operations and the unused codes, whose values are drawn class by class to cover every tag code.

// File: rtl/numreg_pkg.sv
package numreg_pkg;

   typedef enum logic [1:0] {
      TAG_VALID   = 2'b00,
      TAG_ZERO    = 2'b01,
      TAG_SPECIAL = 2'b10,
      TAG_EMPTY   = 2'b11
   } tag_e;

   typedef enum logic [2:0] {
      OP_NOP   = 3'd0,
      OP_PUSH  = 3'd1,
      OP_POP   = 3'd2,
      OP_READ  = 3'd3,
      OP_WRITE = 3'd4,
      OP_FREE  = 3'd5
   } op_e;

endpackage

// File: rtl/numreg_tagclass.sv
module numreg_tagclass
   import numreg_pkg::*;
#(
   parameter int EXPW = 15,
   parameter int SIGW = 64
) (
   input  logic [EXPW-1:0] exp_i,
   input  logic [SIGW-1:0] sig_i,
   output tag_e            tag_o
);

   localparam logic [EXPW-1:0] EXP_MAX = '1;

   logic exp_zero, exp_max, sig_zero, int_bit;

   assign exp_zero = (exp_i == '0);
   assign exp_max  = (exp_i == EXP_MAX);
   assign sig_zero = (sig_i == '0);
   assign int_bit  = sig_i[SIGW-1];

   always_comb begin
      if (exp_zero && sig_zero)      tag_o = TAG_ZERO;
      else if (exp_max)              tag_o = TAG_SPECIAL;
      else if (exp_zero)             tag_o = TAG_SPECIAL;  // denormal
      else if (!int_bit)             tag_o = TAG_SPECIAL;  // unnormal
      else                           tag_o = TAG_VALID;
   end

endmodule

// File: rtl/numreg_ptr.sv
module numreg_ptr #(
   parameter int AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dec_en,
   input  logic          inc_en,
   input  logic [AW-1:0] idx_i,
   output logic [AW-1:0] top_o,
   output logic [AW-1:0] below_o,
   output logic [AW-1:0] rel_o
);

   logic [AW-1:0] top_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       top_q <= '0;
      else if (dec_en)  top_q <= top_q - 1'b1;
      else if (inc_en)  top_q <= top_q + 1'b1;
   end

   // modulo arithmetic falls out of the AW-bit width
   assign top_o   = top_q;
   assign below_o = top_q - 1'b1;
   assign rel_o   = top_q + idx_i;

endmodule

// File: rtl/numreg_file.sv
module numreg_file #(
   parameter int NREG = 8,
   parameter int DW   = 80,
   localparam int AW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);

   logic [DW-1:0] rows [NREG];

   for (genvar k = 0; k < NREG; k++) begin : g_row
      logic [DW-1:0] row_q;
      always_ff @(posedge clk) begin
         if (we_i && (waddr_i == AW'(k))) row_q <= wdata_i;
      end
      assign rows[k] = row_q;
   end

   assign rdata_o = rows[raddr_i];

endmodule

// File: rtl/numreg_stack.sv
module numreg_stack
   import numreg_pkg::*;
#(
   parameter int  NREG = 8,
   parameter int  EXPW = 15,
   parameter int  SIGW = 64,
   parameter int  DW   = 1 + EXPW + SIGW,
   localparam int AW   = $clog2(NREG),
   localparam int TW   = 2 * NREG
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    op_i,
   input  logic [AW-1:0] idx_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o,
   output logic [AW-1:0] top_o,
   output logic [TW-1:0] tagword_o,
   output logic          ovf_o,
   output logic          unf_o
);

   // elaboration-time parameter checks
   if (NREG < 2 || (1 << AW) != NREG) begin : g_bad_depth
      $error("numreg_stack: NREG must be a power of two of at least 2");
   end
   if (DW != 1 + EXPW + SIGW) begin : g_bad_width
      $error("numreg_stack: DW must equal 1 + EXPW + SIGW");
   end

   function automatic tag_e tag_at(input logic [TW-1:0] tw, input logic [AW-1:0] k);
      return tag_e'(tw[{k, 1'b0} +: 2]);
   endfunction

   op_e           op;
   logic [AW-1:0] top, below, rel;
   logic [TW-1:0] tagw;
   tag_e          new_tag;
   logic [DW-1:0] rf_rdata;

   logic          push_ok, push_ovf, pop_ok, pop_unf, read_unf;
   logic          we;
   logic [AW-1:0] waddr, raddr;

   assign op = op_e'(op_i);

   numreg_ptr #(.AW(AW)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .dec_en  (push_ok),
      .inc_en  (pop_ok),
      .idx_i   (idx_i),
      .top_o   (top),
      .below_o (below),
      .rel_o   (rel)
   );

   numreg_tagclass #(.EXPW(EXPW), .SIGW(SIGW)) u_cls (
      .exp_i (wdata_i[DW-2 -: EXPW]),
      .sig_i (wdata_i[SIGW-1:0]),
      .tag_o (new_tag)
   );

   always_comb begin
      push_ok  = (op == OP_PUSH) && (tag_at(tagw, below) == TAG_EMPTY);
      push_ovf = (op == OP_PUSH) && (tag_at(tagw, below) != TAG_EMPTY);
      pop_ok   = (op == OP_POP)  && (tag_at(tagw, top)   != TAG_EMPTY);
      pop_unf  = (op == OP_POP)  && (tag_at(tagw, top)   == TAG_EMPTY);
      read_unf = (op == OP_READ) && (tag_at(tagw, rel)   == TAG_EMPTY);
      we       = push_ok || (op == OP_WRITE);
      waddr    = push_ok ? below : rel;
      raddr    = (op == OP_POP) ? top : rel;
   end

   numreg_file #(.NREG(NREG), .DW(DW)) u_file (
      .clk     (clk),
      .we_i    (we),
      .waddr_i (waddr),
      .wdata_i (wdata_i),
      .raddr_i (raddr),
      .rdata_o (rf_rdata)
   );

   // one tag register per physical entry, packed by physical index
   for (genvar k = 0; k < NREG; k++) begin : g_tag
      logic [1:0] tag_q;
      logic       set_k, clr_k;
      assign set_k = we && (waddr == AW'(k));
      assign clr_k = (pop_ok && (top == AW'(k))) ||
                     ((op == OP_FREE) && (rel == AW'(k)));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      tag_q <= TAG_EMPTY;
         else if (set_k)  tag_q <= new_tag;
         else if (clr_k)  tag_q <= TAG_EMPTY;
      end
      assign tagw[2*k +: 2] = tag_q;
   end

   logic [DW-1:0] rdata_q;
   logic          ovf_q, unf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         ovf_q <= push_ovf;
         unf_q <= pop_unf || read_unf;
      end
   end

   always_ff @(posedge clk) begin
      if (op == OP_POP || op == OP_READ) rdata_q <= rf_rdata;
   end

   assign rdata_o   = rdata_q;
   assign top_o     = top;
   assign tagword_o = tagw;
   assign ovf_o     = ovf_q;
   assign unf_o     = unf_q;

endmodule

// File: rtl/numreg_stack_chk.sv
module numreg_stack_chk #(
   parameter int  NREG = 8,
   localparam int AW   = $clog2(NREG),
   localparam int TW   = 2 * NREG
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    op_i,
   input logic [AW-1:0] top_o,
   input logic [TW-1:0] tagword_o,
   input logic          ovf_o,
   input logic          unf_o
);

   function automatic logic [1:0] tag_at(input logic [TW-1:0] tw, input logic [AW-1:0] k);
      return tw[{k, 1'b0} +: 2];
   endfunction

   logic [AW-1:0] below, above;
   assign below = top_o - 1'b1;
   assign above = top_o + 1'b1;

   assert_push_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd1 && tag_at(tagword_o, below) == 2'b11)
      |=> (top_o == $past(below)) && !ovf_o);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd1 && tag_at(tagword_o, below) != 2'b11)
      |=> ovf_o && $stable(top_o) && $stable(tagword_o));

   assert_pop_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd2 && tag_at(tagword_o, top_o) != 2'b11)
      |=> (top_o == $past(above)) && (tag_at(tagword_o, $past(top_o)) == 2'b11));

   assert_pop_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd2 && tag_at(tagword_o, top_o) == 2'b11)
      |=> unf_o && !ovf_o && $stable(top_o) && $stable(tagword_o));

   assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_o && unf_o));

   assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 3'd0 || op_i == 3'd6 || op_i == 3'd7)
      |=> $stable(top_o) && $stable(tagword_o) && !ovf_o && !unf_o);

endmodule

bind numreg_stack numreg_stack_chk #(.NREG(NREG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_i      (op_i),
   .top_o     (top_o),
   .tagword_o (tagword_o),
   .ovf_o     (ovf_o),
   .unf_o     (unf_o)
);

// File: tb/tb_numreg_stack.sv
`timescale 1ns/1ps
module tb_numreg_stack;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_i = 3'd0;
   logic [2:0]  idx_i = 3'd0;
   logic [79:0] wdata_i = '0;
   logic [79:0] rdata_o;
   logic [2:0]  top_o;
   logic [15:0] tagword_o;
   logic        ovf_o, unf_o;

   always #2.5 clk = ~clk;

   numreg_stack dut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .idx_i(idx_i), .wdata_i(wdata_i),
      .rdata_o(rdata_o), .top_o(top_o), .tagword_o(tagword_o),
      .ovf_o(ovf_o), .unf_o(unf_o)
   );

   int          n_vec = 0;
   int          n_bad = 0;
   bit          done = 0;

   logic [2:0]  mtop;
   logic [79:0] mreg [8];
   logic [1:0]  mtag [8];

   task automatic chk(input string req, input string what, input logic [79:0] act, input logic [79:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [1:0] cls(input logic [79:0] d);
      logic [14:0] e = d[78:64];
      logic [63:0] s = d[63:0];
      if (e == 0 && s == 0) return 2'b01;
      if (e == 15'h7fff)    return 2'b10;
      if (e == 0)           return 2'b10;
      if (!s[63])           return 2'b10;
      return 2'b00;
   endfunction

   function automatic logic [79:0] gen(input int k);
      logic        sg = 1'($urandom);
      logic [14:0] e  = 15'($urandom);
      logic [63:0] s  = {$urandom, $urandom};
      case (k % 5)
         0: return {sg, 15'd0, 64'd0};
         1: return {sg, 15'h7fff, s};
         2: return {sg, 15'd0, s | 64'd1};
         3: return {sg, e | 15'd1, 1'b0, s[62:0]};
         default: begin
            if (e == 15'h7fff || e == 0) e = 15'h3fff;
            return {sg, e, 1'b1, s[62:0]};
         end
      endcase
   endfunction

   function automatic logic [15:0] mtw();
      logic [15:0] t;
      for (int k = 0; k < 8; k++) t[2*k +: 2] = mtag[k];
      return t;
   endfunction

   task automatic step(input logic [2:0] op, input logic [2:0] idx, input logic [79:0] d);
      logic [2:0]  below = mtop - 3'd1;
      logic [2:0]  rel   = mtop + idx;
      logic        eo = 0, eu = 0, chkrd = 0;
      logic [79:0] erd = '0;
      string       rt, rw;
      op_i = op; idx_i = idx; wdata_i = d;
      rw = "R9";
      case (op)
         3'd1: begin
            if (mtag[below] == 2'b11) begin
               mtop = below; mreg[below] = d; mtag[below] = cls(d); rt = "R2"; rw = "R10";
            end else begin eo = 1; rt = "R3"; end
         end
         3'd2: begin
            if (mtag[mtop] == 2'b11) begin eu = 1; rt = "R5"; end
            else begin
               erd = mreg[mtop]; chkrd = 1; mtag[mtop] = 2'b11; mtop = mtop + 3'd1; rt = "R4";
            end
         end
         3'd3: begin
            rt = "R6";
            if (mtag[rel] == 2'b11) eu = 1;
            else begin erd = mreg[rel]; chkrd = 1; end
         end
         3'd4: begin mreg[rel] = d; mtag[rel] = cls(d); rt = "R7"; rw = "R10"; end
         3'd5: begin mtag[rel] = 2'b11; rt = "R8"; end
         default: rt = "R11";
      endcase
      @(negedge clk);
      op_i = 3'd0;
      chk(rt, "top", 80'(top_o), 80'(mtop));
      chk(rw, "tagword", 80'(tagword_o), 80'(mtw()));
      chk(eo ? "R3" : rt, "ovf", 80'(ovf_o), 80'(eo));
      chk(eu ? "R5" : rt, "unf", 80'(unf_o), 80'(eu));
      if (chkrd) chk(rt, "rdata", rdata_o, erd);
   endtask

   initial begin
      mtop = 3'd0;
      for (int k = 0; k < 8; k++) mtag[k] = 2'b11;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "top", 80'(top_o), 80'd0);
      chk("R1", "tagword", 80'(tagword_o), 80'hffff);
      chk("R1", "flags", 80'({ovf_o, unf_o}), 80'd0);

      // R2/R10 fill all slots, one value class after another
      for (int i = 0; i < 8; i++) step(3'd1, 3'd0, gen(i));
      // R3 ninth push overflows
      step(3'd1, 3'd0, gen(4));
      // R6 every index on a full stack
      for (int i = 0; i < 8; i++) step(3'd3, 3'(i), '0);
      // R7 overwrite, R8 free, R5 read of the freed slot
      step(3'd4, 3'd3, gen(0));
      step(3'd3, 3'd3, '0);
      step(3'd5, 3'd5, '0);
      step(3'd3, 3'd5, '0);
      // R4 pops down onto the freed slot, then R5 underflow
      for (int i = 0; i < 6; i++) step(3'd2, 3'd0, '0);
      // R11 idle and unused codes
      step(3'd0, 3'd0, gen(4));
      step(3'd6, 3'd2, gen(4));
      step(3'd7, 3'd1, gen(4));
      // empty everything, then underflow on pop and read
      for (int i = 0; i < 8; i++) step(3'd5, 3'(i), '0);
      step(3'd2, 3'd0, '0);
      step(3'd3, 3'd4, '0);
      // walk TOP around the ring, reading every ST(i) at each position
      for (int t = 0; t < 10; t++) begin
         step(3'd1, 3'd0, gen(t));
         for (int i = 0; i < 8; i++) step(3'd3, 3'(i), '0);
      end
      // weighted random mix
      for (int n = 0; n < 6000; n++) begin
         int r = int'($urandom % 10);
         logic [2:0] op;
         case (r)
            0, 1, 2: op = 3'd1;
            3, 4:    op = 3'd2;
            5:       op = 3'd3;
            6:       op = 3'd4;
            7:       op = 3'd5;
            8:       op = 3'd0;
            default: op = 3'(6 + ($urandom % 2));
         endcase
         step(op, 3'($urandom), gen(int'($urandom % 7)));
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule